// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO Controller

This block is a single-clock FIFO with an 18-bit data path and a register-array store whose depth is a power of two set by a parameter. While master reset is held, a clock edge samples a mode input. That sample selects one of two read modes, and the choice holds until the next master reset:

- **Standard mode.** A read strobe returns the next word on the registered output one clock later.
- **Fall-through mode.** The oldest word is moved to the output by itself, with no read strobe. A read strobe acknowledges that word and consumes it.

Two shared flag outputs change meaning with the mode. In standard mode they report empty and full. In fall-through mode they report that a word is presented and that a write can be accepted.

Three further flags behave the same in both modes. The half-full flag has a fixed threshold. The almost-empty and almost-full flags compare against offsets that arrive from a separate offset register block. A synchronous partial reset empties the FIFO in mid-operation and keeps the latched mode. Every flag is active low.

Top module: `dmf_fifo`

## Requirements
- R1: The mode input is captured on clock edges while rst_ni is low (1 = fall-through, 0 = standard). It keeps its effect after reset is released, whatever the mode input does afterwards.
- R2: In standard mode, a read accepted at a clock edge puts the oldest word on rdata_o after that edge. Words leave in write order.
- R3: In fall-through mode, a word written into an empty FIFO at edge N is on rdata_o after edge N+1, with no read strobe.
- R4: In standard mode, ef_or_no is low exactly when the word count is 0, and ff_ir_no is low exactly when the count equals the depth.
- R5: In fall-through mode, ef_or_no is low exactly when a word is presented on rdata_o, and ff_ir_no is low exactly when the count is below the depth. The presented word is part of the count.
- R6: hf_no is low exactly when the count is greater than half the depth, in both modes.
- R7: pae_no is low exactly when the count is at or below ae_ofs_i.
- R8: paf_no is low exactly when the depth minus the count is at or below af_ofs_i.
- R9: A write while the count equals the depth is dropped. A read while nothing can be read is ignored: in standard mode that means the count is 0, and in fall-through mode it means no word is presented. Neither changes the stored words or rdata_o.
- R10: Driving prs_ni low for one edge empties the FIFO and keeps the latched mode.
- R11: In fall-through mode, reading the last presented word raises ef_or_no after that edge. A word written later is presented within two clocks.
- R12: A write and a read accepted at the same edge leave the count unchanged and keep the word order.
- R13: Master reset clears rdata_o to 0 and sets the flags of an empty FIFO for the selected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Master reset, active low, asynchronous; the mode is sampled while it is low |
| mode_fwft_i | input | 1 | Mode select sampled during master reset (1 = fall-through) |
| prs_ni | input | 1 | Partial reset, active low, synchronous |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 18 | Write data |
| rd_en_i | input | 1 | Read strobe, or acknowledge in fall-through mode |
| rdata_o | output | 18 | Registered read data |
| ae_ofs_i | input | AW+1 | Almost-empty offset, in words from empty |
| af_ofs_i | input | AW+1 | Almost-full offset, in words from full |
| ef_or_no | output | 1 | Empty (standard) or word presented (fall-through), active low |
| ff_ir_no | output | 1 | Full (standard) or input ready (fall-through), active low |
| hf_no | output | 1 | Above half depth, active low |
| pae_no | output | 1 | Almost empty, active low |
| paf_no | output | 1 | Almost full, active low |

## Verification
In fall-through mode, consuming the presented word and moving the next word out of the array happen on the same edge. The bench provokes this by reading a full FIFO back to back. It then checks that every read leaves the next word on the output one clock later, with no gap. In standard mode, a write and a read are driven together at a mid-level fill. The bench judges the result by the unchanged almost-empty flag and by draining exactly the expected words in order.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  localparam int unsigned DATA_W = 18;
  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} fifo_mode_e;
endpackage

// File: rtl/dmf_mem.sv
module dmf_mem #(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dmf_ctrl.sv
module dmf_ctrl
  import dmf_pkg::*;
#(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 4,
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          prs_ni,
  input  fifo_mode_e    mode_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          out_valid_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] mcnt_q, total;
  logic          ov_q, fwft, full, wr_ok, rd_ok, pop;
  logic [DW-1:0] dout_q;

  assign fwft  = (mode_i == MODE_FWFT);
  assign total = mcnt_q + CW'(ov_q);
  assign full  = (total == CW'(DEPTH));
  assign wr_ok = wr_en_i & ~full;
  // fall-through: a read acknowledges the presented word
  assign rd_ok = fwft ? (rd_en_i & ov_q) : (rd_en_i & (mcnt_q != '0));
  // fall-through: refill the output stage whenever it is free or being consumed
  assign pop   = fwft ? ((mcnt_q != '0) & (~ov_q | rd_ok)) : rd_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      mcnt_q <= '0;
      ov_q   <= 1'b0;
      dout_q <= '0;
    end else if (!prs_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      mcnt_q <= '0;
      ov_q   <= 1'b0;
    end else begin
      if (wr_ok) wptr_q <= wptr_q + 1'b1;
      if (pop) begin
        rptr_q <= rptr_q + 1'b1;
        dout_q <= mem_rdata_i;
      end
      mcnt_q <= mcnt_q + CW'(wr_ok) - CW'(pop);
      ov_q   <= fwft & (pop | (ov_q & ~rd_ok));
    end
  end

  assign we_o        = wr_ok & prs_ni;
  assign waddr_o     = wptr_q;
  assign raddr_o     = rptr_q;
  assign rdata_o     = dout_q;
  assign count_o     = total;
  assign out_valid_o = ov_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    total <= CW'(DEPTH)); // R9
  AST_FULL_WR_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prs_ni && wr_en_i && (total == CW'(DEPTH)) |=> $stable(wptr_q)); // R9
  AST_EMPTY_RD_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prs_ni && !fwft && rd_en_i && (mcnt_q == '0) |=> $stable(rptr_q)); // R9
  AST_PRS_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prs_ni |=> (mcnt_q == '0) && !ov_q); // R10
  AST_RW_KEEPS_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prs_ni && !fwft && wr_en_i && rd_en_i && (mcnt_q != '0) && (total != CW'(DEPTH))
    |=> $stable(mcnt_q)); // R12
  AST_FWFT_LAST_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prs_ni && fwft && rd_en_i && ov_q && (mcnt_q == '0) |=> !ov_q); // R11
endmodule

// File: rtl/dmf_flags.sv
module dmf_flags
  import dmf_pkg::*;
#(
  parameter int unsigned AW = 4,
  localparam int unsigned CW = AW + 1
) (
  input  fifo_mode_e    mode_i,
  input  logic [CW-1:0] count_i,
  input  logic          out_valid_i,
  input  logic [CW-1:0] ae_ofs_i,
  input  logic [CW-1:0] af_ofs_i,
  output logic          ef_or_no,
  output logic          ff_ir_no,
  output logic          hf_no,
  output logic          pae_no,
  output logic          paf_no
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned HALF  = DEPTH / 2;

  logic          fwft;
  logic [CW-1:0] free;

  assign fwft = (mode_i == MODE_FWFT);
  assign free = CW'(DEPTH) - count_i;

  always_comb begin
    if (fwft) begin
      ef_or_no = ~out_valid_i;
      ff_ir_no = (count_i == CW'(DEPTH));
    end else begin
      ef_or_no = (count_i != '0);
      ff_ir_no = (count_i != CW'(DEPTH));
    end
    hf_no  = ~(count_i > CW'(HALF));
    pae_no = ~(count_i <= ae_ofs_i);
    paf_no = ~(free <= af_ofs_i);
  end
endmodule

// File: rtl/dmf_fifo.sv
module dmf_fifo
  import dmf_pkg::*;
#(
  parameter int unsigned AW = 4,
  localparam int unsigned DW = DATA_W,
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_fwft_i,
  input  logic          prs_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_en_i,
  output logic [DW-1:0] rdata_o,
  input  logic [CW-1:0] ae_ofs_i,
  input  logic [CW-1:0] af_ofs_i,
  output logic          ef_or_no,
  output logic          ff_ir_no,
  output logic          hf_no,
  output logic          pae_no,
  output logic          paf_no
);
  fifo_mode_e    mode_q;
  logic          run_q;
  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] mem_rdata;
  logic [CW-1:0] count;
  logic          out_valid;

  // mode is sampled by the clock while master reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= fifo_mode_e'(mode_fwft_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= 1'b1;
  end

  dmf_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .raddr_i (raddr),
    .rdata_o (mem_rdata)
  );

  dmf_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .prs_ni      (prs_ni),
    .mode_i      (mode_q),
    .wr_en_i     (wr_en_i),
    .rd_en_i     (rd_en_i),
    .mem_rdata_i (mem_rdata),
    .we_o        (we),
    .waddr_o     (waddr),
    .raddr_o     (raddr),
    .rdata_o     (rdata_o),
    .count_o     (count),
    .out_valid_o (out_valid)
  );

  dmf_flags #(.AW(AW)) u_flags (
    .mode_i      (mode_q),
    .count_i     (count),
    .out_valid_i (out_valid),
    .ae_ofs_i    (ae_ofs_i),
    .af_ofs_i    (af_ofs_i),
    .ef_or_no    (ef_or_no),
    .ff_ir_no    (ff_ir_no),
    .hf_no       (hf_no),
    .pae_no      (pae_no),
    .paf_no      (paf_no)
  );

  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> $stable(mode_q)); // R1
  AST_STD_NOT_EMPTY_AND_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STD) |-> (ef_or_no || ff_ir_no)); // R4
  AST_FWFT_READY_HAS_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_FWFT) && !ef_or_no |-> !pae_no || (ae_ofs_i == '0) || (count != '0)); // R5
endmodule

// File: tb/tb_dmf_fifo.sv
`timescale 1ns/1ps
module tb_dmf_fifo;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_fwft = 1'b0;
  logic        prs_ni = 1'b1;
  logic        wr_en = 1'b0;
  logic [17:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [17:0] rdata;
  logic [4:0]  ae_ofs = 5'd3;
  logic [4:0]  af_ofs = 5'd2;
  logic        ef_or_n, ff_ir_n, hf_n, pae_n, paf_n;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  dmf_fifo #(.AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_fwft_i(mode_fwft), .prs_ni(prs_ni),
    .wr_en_i(wr_en), .wdata_i(wdata), .rd_en_i(rd_en), .rdata_o(rdata),
    .ae_ofs_i(ae_ofs), .af_ofs_i(af_ofs), .ef_or_no(ef_or_n), .ff_ir_no(ff_ir_n),
    .hf_no(hf_n), .pae_no(pae_n), .paf_no(paf_n)
  );

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic cyc(bit w, logic [17:0] d, bit r);
    wr_en = w; wdata = d; rd_en = r;
    @(posedge clk); #2;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic mreset(bit fwft);
    rst_ni = 1'b0; mode_fwft = fwft;
    repeat (2) @(posedge clk);
    #2 rst_ni = 1'b1;
    mode_fwft = ~fwft; // R1: later changes must have no effect
  endtask

  task automatic t_std_reset;
    mreset(1'b0);
    chk("R13 rdata", rdata, 0);
    chk("R4 empty", ef_or_n, 0);
    chk("R4 full", ff_ir_n, 1);
    chk("R6 hf", hf_n, 1);
    chk("R7 pae", pae_n, 0);
    chk("R8 paf", paf_n, 1);
  endtask

  task automatic t_std_order;
    for (int i = 0; i < 3; i++) cyc(1'b1, 18'h100 + 18'(i), 1'b0);
    chk("R1 no fall-through in std", rdata, 0);
    chk("R4 not empty", ef_or_n, 1);
    for (int i = 0; i < 3; i++) begin
      cyc(1'b0, '0, 1'b1);
      chk("R2 read order", rdata, 18'h100 + 18'(i));
    end
    chk("R4 empty again", ef_or_n, 0);
    cyc(1'b0, '0, 1'b1);
    chk("R9 empty read keeps rdata", rdata, 18'h102);
    chk("R9 empty read keeps empty", ef_or_n, 0);
  endtask

  task automatic t_std_fill;
    for (int i = 1; i <= DEPTH; i++) begin
      cyc(1'b1, 18'h200 + 18'(i), 1'b0);
      if (i == 3)  chk("R7 pae at ofs", pae_n, 0);
      if (i == 4)  chk("R7 pae above ofs", pae_n, 1);
      if (i == 8)  chk("R6 hf at half", hf_n, 1);
      if (i == 9)  chk("R6 hf above half", hf_n, 0);
      if (i == 13) chk("R8 paf free 3", paf_n, 1);
      if (i == 14) chk("R8 paf free 2", paf_n, 0);
      if (i == 15) chk("R4 not full", ff_ir_n, 1);
    end
    chk("R4 full", ff_ir_n, 0);
    cyc(1'b1, 18'h3BAD, 1'b0);
    chk("R9 full write keeps full", ff_ir_n, 0);
    for (int i = 1; i <= DEPTH; i++) begin
      cyc(1'b0, '0, 1'b1);
      chk("R9 full write dropped, order kept", rdata, 18'h200 + 18'(i));
    end
    chk("R9 drained after depth reads", ef_or_n, 0);
  endtask

  task automatic t_std_rw;
    int n;
    for (int i = 0; i < 3; i++) cyc(1'b1, 18'h300 + 18'(i), 1'b0);
    cyc(1'b1, 18'h303, 1'b1);
    chk("R12 rw read data", rdata, 18'h300);
    chk("R12 rw count kept", pae_n, 0);
    n = 0;
    while (ef_or_n && n < 8) begin
      cyc(1'b0, '0, 1'b1);
      n++;
      chk("R12 rw order", rdata, 18'h300 + 18'(n));
    end
    chk("R12 rw word count", n, 3);
  endtask

  task automatic t_prs;
    for (int i = 0; i < 5; i++) cyc(1'b1, 18'h400 + 18'(i), 1'b0);
    cyc(1'b0, '0, 1'b1);
    chk("R2 pre-prs read", rdata, 18'h400);
    prs_ni = 1'b0;
    @(posedge clk); #2;
    prs_ni = 1'b1;
    chk("R10 empty after prs", ef_or_n, 0);
    chk("R10 pae after prs", pae_n, 0);
    chk("R10 hf after prs", hf_n, 1);
    cyc(1'b1, 18'h4AA, 1'b0);
    chk("R10 mode kept, no fall-through", rdata, 18'h400);
    cyc(1'b0, '0, 1'b1);
    chk("R10 restart order", rdata, 18'h4AA);
  endtask

  task automatic t_fwft_basic;
    mreset(1'b1);
    chk("R13 fwft rdata", rdata, 0);
    chk("R5 not ready", ef_or_n, 1);
    chk("R5 input ready", ff_ir_n, 0);
    cyc(1'b0, '0, 1'b1);
    chk("R9 read while not ready", ef_or_n, 1);
    cyc(1'b1, 18'h500, 1'b0);
    chk("R3 not yet presented", ef_or_n, 1);
    cyc(1'b0, '0, 1'b0);
    chk("R3 presented", ef_or_n, 0);
    chk("R3 fall-through data", rdata, 18'h500);
    cyc(1'b0, '0, 1'b1);
    chk("R11 ready drops", ef_or_n, 1);
    cyc(1'b1, 18'h501, 1'b0);
    cyc(1'b0, '0, 1'b0);
    chk("R11 next word ready", ef_or_n, 0);
    chk("R11 next word data", rdata, 18'h501);
    cyc(1'b0, '0, 1'b1);
  endtask

  task automatic t_fwft_fill;
    for (int i = 0; i < DEPTH; i++) cyc(1'b1, 18'h600 + 18'(i), 1'b0);
    chk("R5 input not ready when full", ff_ir_n, 1);
    chk("R6 hf fwft", hf_n, 0);
    chk("R8 paf fwft", paf_n, 0);
    cyc(1'b1, 18'h6FF, 1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R5 presented before read", ef_or_n, 0);
      chk("R11 back-to-back data", rdata, 18'h600 + 18'(i));
      cyc(1'b0, '0, 1'b1);
      if (i == 0) chk("R5 input ready after read", ff_ir_n, 0);
    end
    chk("R9 full write dropped fwft", ef_or_n, 1);
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_std_reset();
    t_std_order();
    t_std_fill();
    t_std_rw();
    t_prs();
    t_fwft_basic();
    t_fwft_fill();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule